// File: doc/BRIEF.md
# Stepped Sine Reference Sequencer

This block turns a slow timebase enable, nominally 32768 pulses per second, into a stepped sine-wave reference code for an external DAC. A two-bit select input chooses one of three output frequencies (20 Hz, 25 Hz or 50 Hz at the nominal tick rate). A different tick rate scales all three in proportion. A reload divider counts ticks and issues a step every N ticks. Each step moves a nine-level amplitude index one place along a triangle walk, 0 up to 8 and back down to 0. One output period is 16 steps.

The index is a code whose level 4 is the waveform midpoint. Level 0 is the negative peak and level 8 is the positive peak. The DAC maps the index to the nine piecewise-linear voltages. A polarity flag marks the positive half of the wave, and a one-cycle strobe marks each step. The fourth select code turns the generator off. The output-enable flag drops so that the DAC output can be released and an external sine can drive the reference node instead.

Top module: `sine_step_seq`

## Requirements
- R1: While `rst` is sampled high on a clock edge, `level` becomes 4, `pos_half` becomes 0, `step_stb` becomes 0 and `drive_en` becomes 0. The walk direction becomes rising, so the first step after reset moves `level` to 5.
- R2: A step happens on the N-th counted tick after the previous step. N is 102 for `sel`=2'b00, 82 for `sel`=2'b01 and 41 for `sel`=2'b10. Each N is the tick rate divided by 16 times the target frequency, rounded to the nearest integer. At reset, N is taken from `sel`, and code 2'b11 loads the 2'b00 value.
- R3: Successive steps move `level` by exactly one. The level rises to 8, falls to 0 and rises again, so one period is 16 steps, or 16·N ticks.
- R4: `pos_half` is 1 exactly when `level` is greater than 4.
- R5: `step_stb` is high for the single cycle that follows the edge on which `level` takes its new value. `level` never changes without it.
- R6: `drive_en` is registered: after an edge where `sel` is 2'b11 it is 0, otherwise it is 1. While `sel` is 2'b11, ticks are ignored, no step occurs, and `level`, `pos_half` and the divider count are held.
- R7: A change of `sel` does not shorten or lengthen the interval in progress. The new N applies only from the next step onwards.
- R8: A cycle with `tick` low leaves the divider count unchanged. The interval is measured in ticks, not in clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase enable, one cycle per crystal period |
| sel | input | 2 | Frequency select: 00, 01, 10 pick a rate, 11 turns the generator off |
| level | output | 4 | Amplitude index 0..8 for the DAC, 4 is the midpoint |
| pos_half | output | 1 | High while the index is above the midpoint |
| step_stb | output | 1 | One-cycle pulse on every step |
| drive_en | output | 1 | Output enable for the DAC driver, low in the off code |

## Verification
The bench runs each select code with a tick on every cycle. This isolates the reload value per code, and the strobe gap and 16-step period are measured directly against 102, 82 and 41. It then runs with ticks on every third cycle, which separates counting ticks from counting clocks. Select changes in the middle of an interval show whether the reload is taken only at a boundary. A stretch in the off code, with ticks still arriving, shows that the index and count freeze and the enable drops.

// File: rtl/sinseq_pkg.sv
package sinseq_pkg;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'b00,
    SEL_MID  = 2'b01,
    SEL_HIGH = 2'b10,
    SEL_OFF  = 2'b11
  } fsel_e;

  // Ticks per step, rounded to nearest: tick_hz / (steps * hz)
  function automatic int reload_for(input int tick_hz, input int steps, input int hz);
    return (tick_hz + (steps * hz) / 2) / (steps * hz);
  endfunction

endpackage

// File: rtl/sinseq_divider.sv
module sinseq_divider #(
  parameter int CW = 7,
  parameter int N0 = 102,
  parameter int N1 = 82,
  parameter int N2 = 41
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       step,
  output logic       step_q
);
  import sinseq_pkg::*;

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;
  logic          running;

  always_comb begin
    case (fsel_e'(sel))
      SEL_MID:  reload = CW'(N1);
      SEL_HIGH: reload = CW'(N2);
      default:  reload = CW'(N0);
    endcase
  end

  assign running = (fsel_e'(sel) != SEL_OFF);
  assign step    = running && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= reload - 1'b1;
      step_q <= 1'b0;
    end else begin
      step_q <= step;
      if (running && tick) begin
        if (cnt == '0) cnt <= reload - 1'b1;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  // R8: idle cycles do not move the count
  a_r8_idle_holds_count: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  // R6: off code freezes the count
  a_r6_off_holds_count: assert property (@(posedge clk) disable iff (rst)
    (fsel_e'(sel) == SEL_OFF) |=> $stable(cnt));

endmodule

// File: rtl/sinseq_walker.sv
module sinseq_walker #(
  parameter int LEVELS = 9,
  parameter int LW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [LW-1:0] level,
  output logic          pos_half
);
  localparam int TOPV = LEVELS - 1;
  localparam int MID  = (LEVELS - 1) / 2;

  logic          rising;
  logic [LW-1:0] nxt_idx;
  logic          nxt_rise;

  always_comb begin
    nxt_idx  = level;
    nxt_rise = rising;
    if (rising) begin
      if (level == LW'(TOPV)) begin
        nxt_idx  = level - 1'b1;
        nxt_rise = 1'b0;
      end else begin
        nxt_idx  = level + 1'b1;
      end
    end else begin
      if (level == '0) begin
        nxt_idx  = level + 1'b1;
        nxt_rise = 1'b1;
      end else begin
        nxt_idx  = level - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= LW'(MID);
      rising   <= 1'b1;
      pos_half <= 1'b0;
    end else if (step) begin
      level    <= nxt_idx;
      rising   <= nxt_rise;
      pos_half <= (nxt_idx > LW'(MID));
    end
  end

  // R4: polarity flag agrees with the index after every step
  a_r4_polarity: assert property (@(posedge clk) disable iff (rst)
    step |=> (pos_half == (level > LW'(MID))));

  // R3: index stays inside the table
  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    step |=> (level <= LW'(TOPV)));

endmodule

// File: rtl/sine_step_seq.sv
module sine_step_seq #(
  parameter int TICK_HZ = 32768,
  parameter int LEVELS  = 9,
  parameter int HZ_LOW  = 20,
  parameter int HZ_MID  = 25,
  parameter int HZ_HIGH = 50,
  localparam int LW     = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [1:0]    sel,
  output logic [LW-1:0] level,
  output logic          pos_half,
  output logic          step_stb,
  output logic          drive_en
);
  import sinseq_pkg::*;

  localparam int STEPS = 2 * (LEVELS - 1);
  localparam int N0    = reload_for(TICK_HZ, STEPS, HZ_LOW);
  localparam int N1    = reload_for(TICK_HZ, STEPS, HZ_MID);
  localparam int N2    = reload_for(TICK_HZ, STEPS, HZ_HIGH);
  localparam int NMAX  = (N0 > N1) ? ((N0 > N2) ? N0 : N2) : ((N1 > N2) ? N1 : N2);
  localparam int CW    = $clog2(NMAX + 1);

  logic step;

  sinseq_divider #(.CW(CW), .N0(N0), .N1(N1), .N2(N2)) u_div (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .sel    (sel),
    .step   (step),
    .step_q (step_stb)
  );

  sinseq_walker #(.LEVELS(LEVELS), .LW(LW)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .level    (level),
    .pos_half (pos_half)
  );

  always_ff @(posedge clk) begin
    if (rst) drive_en <= 1'b0;
    else     drive_en <= (fsel_e'(sel) != SEL_OFF);
  end

  // R5: the index only moves together with the strobe
  a_r5_change_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(level)) |-> step_stb);

  // R3: each step moves the index by one place
  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    step_stb |-> ((level == $past(level) + 1'b1) || ($past(level) == level + 1'b1)));

  // R6: off code gives no step and holds the index
  a_r6_off_freezes: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == 2'b11) |-> (!step_stb && $stable(level) && !drive_en));

endmodule

// File: tb/tb_sine_step_seq.sv
module tb_sine_step_seq;

  logic       clk = 1'b0;
  logic       rst;
  logic       tick;
  logic [1:0] sel;
  logic [3:0] level;
  logic       pos_half, step_stb, drive_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sine_step_seq dut (
    .clk(clk), .rst(rst), .tick(tick), .sel(sel),
    .level(level), .pos_half(pos_half), .step_stb(step_stb), .drive_en(drive_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ticks_for(input logic [1:0] s);
    if (s == 2'b01) return 82;
    if (s == 2'b10) return 41;
    return 102;
  endfunction

  // Behavioural reference: phase 0..15 around the triangle, ticks counted up
  int  m_phase, m_seen, m_need;
  bit  m_stb, m_en;
  bit  cmp_on = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 4; m_seen = 0; m_need = ticks_for(sel); m_stb = 0; m_en = 0;
    end else begin
      m_en  = (sel != 2'b11);
      m_stb = 0;
      if (tick && sel != 2'b11) begin
        m_seen++;
        if (m_seen == m_need) begin
          m_phase = (m_phase + 1) % 16;
          m_stb   = 1;
          m_seen  = 0;
          m_need  = ticks_for(sel);
        end
      end
    end
    #2;
    if (cmp_on) begin
      int exp_lvl;
      exp_lvl = (m_phase <= 8) ? m_phase : 16 - m_phase;
      chk("R3 level walk", level, exp_lvl);
      chk("R4 pos_half", pos_half, exp_lvl > 4);
      chk("R5 step_stb", step_stb, m_stb);
      chk("R6 drive_en", drive_en, m_en);
    end
  end

  // Strobe gap and full period with a tick every cycle
  task automatic measure(input logic [1:0] s, input int n);
    int gap;
    sel = s; tick = 1'b1;
    repeat (2) begin
      do @(negedge clk); while (!step_stb);
    end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!step_stb);
    chk("R2 step interval", gap, n);
    gap = 0;
    for (int k = 0; k < 16; k++) begin
      do begin @(negedge clk); gap++; end while (!step_stb);
    end
    chk("R3 period in ticks", gap, 16 * n);
  endtask

  initial begin
    int held;
    rst = 1'b1; tick = 1'b0; sel = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 reset level", level, 4);
    chk("R1 reset pos_half", pos_half, 0);
    chk("R1 reset step_stb", step_stb, 0);
    chk("R1 reset drive_en", drive_en, 0);
    rst = 1'b0; cmp_on = 1;
    tick = 1'b1;
    do @(negedge clk); while (!step_stb);
    chk("R1 first step rises", level, 5);

    measure(2'b00, 102);
    measure(2'b01, 82);
    measure(2'b10, 41);

    // R8: ticks on every third cycle
    sel = 2'b01;
    for (int i = 0; i < 3000; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end

    // R7: select changes mid-interval
    for (int i = 0; i < 1500; i++) begin
      tick = 1'b1;
      if (i % 57 == 20) sel = (sel == 2'b00) ? 2'b10 : 2'b00;
      @(negedge clk);
    end

    // R6: off code with ticks still arriving
    sel = 2'b11; tick = 1'b1;
    @(negedge clk);
    held = level;
    repeat (300) @(negedge clk);
    chk("R6 level held while off", level, held);
    chk("R6 drive_en low while off", drive_en, 0);
    sel = 2'b10;
    repeat (800) @(negedge clk);

    // R1: reset mid-run
    rst = 1'b1; sel = 2'b01;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset mid-run level", level, 4);
    repeat (300) @(negedge clk);

    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule